// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a clocked two-port memory. A left port and a right port each have their own enable, direction select, output enable, address, write data, read data and an active-low interrupt line. Both ports can reach every word of the array in the same cycle. Read data is registered: it appears one clock after the read cycle.

The two topmost words of the address space also serve as mailboxes between the ports. A port posts a message by writing the mailbox that belongs to its partner. That write pulls the partner's interrupt line low. The partner then reads the mailbox word, which returns the stored message and releases its own interrupt line on the same clock edge.

A per-port busy input, active low, stops that port's accesses from touching either interrupt flag. The memory access itself still goes ahead. The mailbox addresses are derived from the address-width parameter, so they always sit at the top two words of whatever depth is built.

Top module: `dpmb_top`

## Requirements
- R1: While reset is high and after it is released, both interrupt outputs are high (nothing pending) and both read-data outputs are zero.
- R2: An access is a write when enable is low and direction select is low. It is a read when enable is low, direction select is high and output enable is low. A read of any address drives its read-data output, one clock later, with the word stored there. The read-data output holds its value in every cycle without a read.
- R3: A left-port write to the all-ones address drives the right interrupt output low from the next clock edge.
- R4: A right-port read of the all-ones address drives the right interrupt output high from the next clock edge.
- R5: A right-port write to the all-ones-but-LSB address drives the left interrupt output low from the next clock edge.
- R6: A left-port read of the all-ones-but-LSB address drives the left interrupt output high from the next clock edge.
- R7: While a port's busy input is low, that port's accesses change neither interrupt flag, but they still write and read memory.
- R8: When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: Both mailbox words store written data and return it on reads, like any other word.
- R10: When both ports write the same address in the same cycle, the left port's data is stored.
- R11: Mailbox accesses in the wrong direction do not change either flag. This covers a port reading its partner's mailbox, a port writing its own mailbox, and an enabled cycle with output enable high and direction select high. Such a cycle is not a read and also leaves read data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_ce_n | input | 1 | Left enable, active low |
| l_we_n | input | 1 | Left direction select: low write, high read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left busy, active low; blocks flag changes |
| l_addr | input | AW | Left address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left registered read data |
| l_int_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right enable, active low |
| r_we_n | input | 1 | Right direction select |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right busy, active low |
| r_addr | input | AW | Right address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right registered read data |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The flag assertions assume that every control input is a known 0 or 1 at each clock edge. They also assume that the busy inputs only change together with the other controls, so that a set or a clear is judged from the inputs seen at that edge alone. The stimulus changes every input only on the falling edge and drives defined idle values between accesses. It reads only words it has written before, so the read-data assertions never meet uninitialised storage.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_e;

    typedef struct packed {
        logic raise_peer;
        logic clear_own;
    } flag_evt_t;

    localparam int PORTS = 2;
    localparam int LEFT  = 0;
    localparam int RIGHT = 1;

    function automatic acc_e classify(input logic ce_n, input logic we_n, input logic oe_n);
        if (ce_n)
            return ACC_NONE;
        if (!we_n)
            return ACC_WRITE;
        if (!oe_n)
            return ACC_READ;
        return ACC_NONE;
    endfunction

endpackage

// File: rtl/dpmb_port_ctl.sv
module dpmb_port_ctl
    import dpmb_pkg::*;
#(
    parameter int AW = 8,
    parameter logic [AW-1:0] SEND_ADDR = '1,
    parameter logic [AW-1:0] RECV_ADDR = '1
) (
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          busy_n,
    input  logic [AW-1:0] addr,
    output logic          wr,
    output logic          rd,
    output flag_evt_t     evt
);
    acc_e acc;

    always_comb begin
        acc            = classify(ce_n, we_n, oe_n);
        wr             = (acc == ACC_WRITE);
        rd             = (acc == ACC_READ);
        evt.raise_peer = wr && busy_n && (addr == SEND_ADDR);
        evt.clear_own  = rd && busy_n && (addr == RECV_ADDR);
    end
endmodule

// File: rtl/dpmb_flag.sv
module dpmb_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (set)
            pend <= 1'b1;
        else if (clr)
            pend <= 1'b0;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set |=> pend);
    assert_clear_only_R4: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !pend);
    assert_flag_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> $stable(pend));
endmodule

// File: rtl/dpmb_mem.sv
module dpmb_mem
    import dpmb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr    [PORTS],
    input  logic          rd    [PORTS],
    input  logic [AW-1:0] addr  [PORTS],
    input  logic [DW-1:0] wdata [PORTS],
    output logic [DW-1:0] rdata [PORTS]
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Right first, left last: the left write wins on an address collision.
    always_ff @(posedge clk) begin
        if (wr[RIGHT])
            store[addr[RIGHT]] <= wdata[RIGHT];
        if (wr[LEFT])
            store[addr[LEFT]] <= wdata[LEFT];
    end

    for (genvar g = 0; g < PORTS; g++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst)
                rdata[g] <= '0;
            else if (rd[g])
                rdata[g] <= store[addr[g]];
        end

        assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
            !rd[g] |=> $stable(rdata[g]));
    end
endmodule

// File: rtl/dpmb_top.sv
module dpmb_top
    import dpmb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_ce_n,
    input  logic          l_we_n,
    input  logic          l_oe_n,
    input  logic          l_busy_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_int_n,
    input  logic          r_ce_n,
    input  logic          r_we_n,
    input  logic          r_oe_n,
    input  logic          r_busy_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_int_n
);
    localparam logic [AW-1:0] MBOX_TO_RIGHT = {AW{1'b1}};
    localparam logic [AW-1:0] MBOX_TO_LEFT  = {{(AW-1){1'b1}}, 1'b0};

    logic          ce_n   [PORTS];
    logic          we_n   [PORTS];
    logic          oe_n   [PORTS];
    logic          busy_n [PORTS];
    logic [AW-1:0] addr   [PORTS];
    logic [DW-1:0] wdata  [PORTS];
    logic [DW-1:0] rdata  [PORTS];
    logic          wr     [PORTS];
    logic          rd     [PORTS];
    logic          pend   [PORTS];
    flag_evt_t     evt    [PORTS];

    assign ce_n[LEFT]   = l_ce_n;   assign ce_n[RIGHT]   = r_ce_n;
    assign we_n[LEFT]   = l_we_n;   assign we_n[RIGHT]   = r_we_n;
    assign oe_n[LEFT]   = l_oe_n;   assign oe_n[RIGHT]   = r_oe_n;
    assign busy_n[LEFT] = l_busy_n; assign busy_n[RIGHT] = r_busy_n;
    assign addr[LEFT]   = l_addr;   assign addr[RIGHT]   = r_addr;
    assign wdata[LEFT]  = l_wdata;  assign wdata[RIGHT]  = r_wdata;

    for (genvar g = 0; g < PORTS; g++) begin : g_port
        localparam logic [AW-1:0] SEND = (g == LEFT) ? MBOX_TO_RIGHT : MBOX_TO_LEFT;
        localparam logic [AW-1:0] RECV = (g == LEFT) ? MBOX_TO_LEFT  : MBOX_TO_RIGHT;

        dpmb_port_ctl #(.AW(AW), .SEND_ADDR(SEND), .RECV_ADDR(RECV)) u_ctl (
            .ce_n   (ce_n[g]),
            .we_n   (we_n[g]),
            .oe_n   (oe_n[g]),
            .busy_n (busy_n[g]),
            .addr   (addr[g]),
            .wr     (wr[g]),
            .rd     (rd[g]),
            .evt    (evt[g])
        );

        dpmb_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (evt[PORTS-1-g].raise_peer),
            .clr  (evt[g].clear_own),
            .pend (pend[g])
        );
    end

    dpmb_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .rd    (rd),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    assign l_rdata = rdata[LEFT];
    assign r_rdata = rdata[RIGHT];
    assign l_int_n = ~pend[LEFT];
    assign r_int_n = ~pend[RIGHT];

    assert_left_post_R3: assert property (@(posedge clk) disable iff (rst)
        (!l_ce_n && !l_we_n && l_busy_n && l_addr == MBOX_TO_RIGHT) |=> !r_int_n);
    assert_right_post_R5: assert property (@(posedge clk) disable iff (rst)
        (!r_ce_n && !r_we_n && r_busy_n && r_addr == MBOX_TO_LEFT) |=> !l_int_n);
    assert_both_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (!l_busy_n && !r_busy_n) |=> ($stable(l_int_n) && $stable(r_int_n)));
endmodule

// File: tb/dpmb_top_test.sv
`timescale 1ns/1ps
module dpmb_top_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int TOPA = (1 << AW) - 1;
    localparam int TOPB = (1 << AW) - 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_ce_n, l_we_n, l_oe_n, l_busy_n, r_ce_n, r_we_n, r_oe_n, r_busy_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic l_int_n, r_int_n;

    always #2 clk = ~clk;

    dpmb_top #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst(rst),
        .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_int_n(l_int_n),
        .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_int_n(r_int_n)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    string tag_q = "R1";
    int cycles = 0;

    // Behavioural reference model
    logic [DW-1:0] m_mem [int];
    logic [DW-1:0] m_lr = '0, m_rr = '0;
    bit m_lpend = 0, m_rpend = 0;

    always @(posedge clk) begin
        bit lw, lr, rw, rr, lset, lclr, rset, rclr;
        tag_q = tag;
        if (rst) begin
            m_lpend = 0; m_rpend = 0; m_lr = '0; m_rr = '0;
        end else begin
            lw = !l_ce_n && !l_we_n;
            lr = !l_ce_n && l_we_n && !l_oe_n;
            rw = !r_ce_n && !r_we_n;
            rr = !r_ce_n && r_we_n && !r_oe_n;
            if (lr) m_lr = m_mem.exists(int'(l_addr)) ? m_mem[int'(l_addr)] : 'x;
            if (rr) m_rr = m_mem.exists(int'(r_addr)) ? m_mem[int'(r_addr)] : 'x;
            rset = lw && l_busy_n && int'(l_addr) == TOPA;
            rclr = rr && r_busy_n && int'(r_addr) == TOPA;
            lset = rw && r_busy_n && int'(r_addr) == TOPB;
            lclr = lr && l_busy_n && int'(l_addr) == TOPB;
            if (rset) m_rpend = 1; else if (rclr) m_rpend = 0;
            if (lset) m_lpend = 1; else if (lclr) m_lpend = 0;
            if (rw) m_mem[int'(r_addr)] = r_wdata;
            if (lw) m_mem[int'(l_addr)] = l_wdata;
        end
    end

    task automatic check(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag_q, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        check("l_int_n", DW'(l_int_n), DW'(!m_lpend));
        check("r_int_n", DW'(r_int_n), DW'(!m_rpend));
        check("l_rdata", l_rdata, m_lr);
        check("r_rdata", r_rdata, m_rr);
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle();
        l_ce_n = 1; l_we_n = 1; l_oe_n = 1; l_busy_n = 1; l_addr = '0; l_wdata = '0;
        r_ce_n = 1; r_we_n = 1; r_oe_n = 1; r_busy_n = 1; r_addr = '0; r_wdata = '0;
    endtask

    task automatic lwr(int a, logic [DW-1:0] d);
        l_ce_n = 0; l_we_n = 0; l_oe_n = 1; l_addr = AW'(a); l_wdata = d;
    endtask
    task automatic lrd(int a);
        l_ce_n = 0; l_we_n = 1; l_oe_n = 0; l_addr = AW'(a);
    endtask
    task automatic rwr(int a, logic [DW-1:0] d);
        r_ce_n = 0; r_we_n = 0; r_oe_n = 1; r_addr = AW'(a); r_wdata = d;
    endtask
    task automatic rrd(int a);
        r_ce_n = 0; r_we_n = 1; r_oe_n = 0; r_addr = AW'(a);
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    initial begin
        idle();
        tag = "R1"; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);

        tag = "R2";
        lwr(5, 16'hA5A5); rwr(9, 16'h1234); step();
        lrd(9); rrd(5); step();
        step();
        l_ce_n = 0; l_we_n = 1; l_oe_n = 1; l_addr = AW'(5); step();
        for (int i = 0; i < 8; i++) begin
            lwr(40 + i, DW'(i * 16'h0111 + 3)); step();
        end
        for (int i = 0; i < 8; i++) begin
            rrd(47 - i); lrd(40 + i); step();
        end

        tag = "R3"; lwr(TOPA, 16'hBEEF); step(); step();
        tag = "R9"; lrd(TOPA); step();
        tag = "R4"; rrd(TOPA); step(); step();
        tag = "R5"; rwr(TOPB, 16'hCAFE); step(); step();
        tag = "R6"; lrd(TOPB); step(); step();

        tag = "R7";
        l_busy_n = 0; lwr(TOPA, 16'h0F0F); step(); step();
        lrd(TOPA); step();
        rwr(TOPB, 16'h7777); step();
        r_busy_n = 0; rrd(TOPB); step();
        l_busy_n = 0; lrd(TOPB); step(); step();
        lwr(TOPA, 16'h1111); step();
        r_busy_n = 0; rrd(TOPA); step(); step();
        l_busy_n = 0; r_busy_n = 0; lrd(TOPB); rrd(TOPA); step();

        tag = "R8";
        lwr(TOPA, 16'h2222); rrd(TOPA); step(); step();
        rwr(TOPB, 16'h3333); lrd(TOPB); step(); step();
        rrd(TOPA); lrd(TOPB); step(); step();

        tag = "R10";
        lwr(20, 16'hAAAA); rwr(20, 16'h5555); step();
        lrd(20); rrd(20); step(); step();

        tag = "R11";
        lwr(TOPA, 16'h4444); rwr(TOPB, 16'h6666); step();
        lrd(TOPA); rrd(TOPB); step(); step();
        lwr(TOPB, 16'h9999); rwr(TOPA, 16'h8888); step(); step();
        r_ce_n = 0; r_we_n = 1; r_oe_n = 1; r_addr = AW'(TOPA);
        l_ce_n = 0; l_we_n = 1; l_oe_n = 1; l_addr = AW'(TOPB); step(); step();
        rrd(TOPA); lrd(TOPB); step(); step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule